// File: doc/BRIEF.md
# Root Port Error Collector

This block sits in a root port and gathers the error messages that arrive from the hierarchy below it. Each message carries a two-bit severity (correctable, non-fatal or fatal) and a 16-bit requester source ID. The block keeps a set of sticky received flags and two source-ID registers. One source register holds the first correctable reporter and the other holds the first uncorrectable reporter. Further messages of the same class only raise a "multiple" flag, so the first offender is not overwritten.

A root command register holds three enables, one per severity. The interrupt condition is true when any enabled severity has its received flag set. In level mode the block drives an INTx-style level that follows this condition. In MSI mode it issues a single-cycle request only when the condition goes from false to true, whether the cause is a message or a command write. The request carries the message number that the platform supplies on an input; that number is also mirrored into the upper bits of the status word. Software writes the command register through one strobe and clears status flags by writing ones through another.

Top module: `rpe_root_collector`

## Requirements
- R1: After a cycle with `rst_n` low, `root_cmd` is 0, status flag bits [6:0] are 0, both source IDs are 0, and `intx` and `msi_req` are low.
- R2: A correctable message (severity 2'b00) sets status bit 0. If bit 0 was already set, it sets bit 1 (multiple correctable) and leaves `cor_src_id` unchanged; otherwise it loads `cor_src_id` with the message source.
- R3: A non-fatal (2'b01) or fatal (2'b10) message sets bit 2 (uncorrectable received). If bit 2 was already set, it sets bit 3 (multiple uncorrectable) and leaves `unc_src_id` unchanged; otherwise it loads `unc_src_id`. A non-fatal message also sets bit 5.
- R4: A fatal message sets bit 6. It also sets bit 4 (first fatal) when bit 2 was clear before the message, and leaves bit 4 untouched otherwise.
- R5: A `sts_clr` write clears exactly the flag bits set in `sts_clr_mask`. Mask zeros leave flags, and both source IDs, unchanged.
- R6: The interrupt condition is the OR of three terms: `root_cmd[0]` AND bit 0, `root_cmd[1]` AND bit 5, `root_cmd[2]` AND bit 6. In level mode (`msi_mode`=0), `intx` shows this condition one cycle after any message, command write or clear. `root_cmd` reads back the last `cmd_wdata` written.
- R7: In MSI mode (`msi_mode`=1), `intx` stays low. `msi_req` pulses for exactly one cycle when the condition changes from false to true, whether the cause is a message or a command write. No pulse is issued while the condition stays true.
- R8: `root_status[31:27]` and `msi_vector` both show `msg_num_in` as sampled on the previous clock edge.
- R9: When a clear and a message occur in the same cycle, the clear is applied first and the message then acts on the cleared flags.
- R10: A message with severity 2'b11 has no effect on the flags or the source IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 00 correctable, 01 non-fatal, 10 fatal, 11 reserved |
| msg_src | input | 16 | Source ID of the message |
| cmd_wr | input | 1 | Write strobe for the root command register |
| cmd_wdata | input | 3 | New enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| sts_clr | input | 1 | Write-1-to-clear strobe for the status flags |
| sts_clr_mask | input | 7 | Flag bits to clear |
| msi_mode | input | 1 | 1 selects the message-signalled interrupt, 0 selects the level |
| msg_num_in | input | 5 | Interrupt message number supplied by the platform |
| root_cmd | output | 3 | Root command register |
| root_status | output | 32 | Flags in [6:0], message number in [31:27], zeros elsewhere |
| cor_src_id | output | 16 | Source of the first correctable error |
| unc_src_id | output | 16 | Source of the first uncorrectable error |
| intx | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message interrupt request |
| msi_vector | output | 5 | Message number carried by the request |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before it first rises. They also assume that `msi_mode` and `msg_num_in` change only while the block is otherwise idle, so that each request and each level can be traced to a single cause. The stimulus keeps to both rules: it changes its inputs at the falling edge, changes the mode only together with a clear, and changes the message number only in a directed step of its own. The bench drives the reserved severity and a simultaneous clear-plus-message on purpose. The assertions for held source IDs and for flags that never rise on their own cover both cases without treating either as illegal.

// File: rtl/rpe_pkg.sv
// Shared definitions for the root port error collector.
// Assumes: flag and enable positions below are the software-visible layout.
package rpe_pkg;

    typedef enum logic [1:0] {
        SEV_COR      = 2'b00,
        SEV_NONFATAL = 2'b01,
        SEV_FATAL    = 2'b10,
        SEV_RSVD     = 2'b11
    } sev_e;

    localparam int FLAG_W  = 7;
    localparam int F_COR   = 0;  // correctable received
    localparam int F_MCOR  = 1;  // multiple correctable received
    localparam int F_UNC   = 2;  // uncorrectable received
    localparam int F_MUNC  = 3;  // multiple uncorrectable received
    localparam int F_FFAT  = 4;  // first uncorrectable was fatal
    localparam int F_NF    = 5;  // non-fatal received
    localparam int F_FAT   = 6;  // fatal received

    localparam int CMD_W   = 3;
    localparam int C_COR   = 0;
    localparam int C_NF    = 1;
    localparam int C_FAT   = 2;

    localparam int SRC_CNT = 2;  // number of source-ID registers
    localparam int S_COR   = 0;
    localparam int S_UNC   = 1;

    // Interrupt condition from a flag set and a command value.
    function automatic logic irq_cond(input logic [FLAG_W-1:0] flags,
                                      input logic [CMD_W-1:0]  cmd);
        return (cmd[C_COR] & flags[F_COR]) |
               (cmd[C_NF]  & flags[F_NF])  |
               (cmd[C_FAT] & flags[F_FAT]);
    endfunction

endpackage

// File: rtl/rpe_src_reg.sv
// Source-ID holding register: loads on a strobe, otherwise holds.
// Assumes: synchronous active-low reset to zero.
module rpe_src_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the source ID when the load strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

endmodule

// File: rtl/rpe_flag_unit.sv
// Status flag tracker. Applies write-1-to-clear first and then the incoming
// message. It decides which source register loads and sets the multiple and
// first-fatal flags. Assumes one message per cycle at most.
module rpe_flag_unit
    import rpe_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    msg_valid,
    input  logic [1:0]              msg_sev,
    input  logic [SRC_W-1:0]        msg_src,
    input  logic                    clr_en,
    input  logic [FLAG_W-1:0]       clr_mask,
    output logic [FLAG_W-1:0]       flags_q,
    output logic [FLAG_W-1:0]       flags_nx,
    output logic [SRC_W-1:0]        cor_src,
    output logic [SRC_W-1:0]        unc_src
);

    logic [FLAG_W-1:0]  flags_eff;
    logic [SRC_CNT-1:0] src_ld;
    logic [SRC_W-1:0]   src_q [SRC_CNT];
    sev_e               sev;

    assign sev = sev_e'(msg_sev);

    // Flags after the clear, which the message then acts on.
    always_comb begin
        flags_eff = clr_en ? (flags_q & ~clr_mask) : flags_q;
    end

    // Next flag value and source-register load strobes for this message.
    always_comb begin
        flags_nx = flags_eff;
        src_ld   = '0;
        if (msg_valid) begin
            case (sev)
                SEV_COR: begin
                    if (flags_eff[F_COR]) flags_nx[F_MCOR] = 1'b1;
                    else                  src_ld[S_COR]    = 1'b1;
                    flags_nx[F_COR] = 1'b1;
                end
                SEV_NONFATAL, SEV_FATAL: begin
                    if (sev == SEV_FATAL) begin
                        if (!flags_eff[F_UNC]) flags_nx[F_FFAT] = 1'b1;
                        flags_nx[F_FAT] = 1'b1;
                    end else begin
                        flags_nx[F_NF] = 1'b1;
                    end
                    if (flags_eff[F_UNC]) flags_nx[F_MUNC] = 1'b1;
                    else                  src_ld[S_UNC]    = 1'b1;
                    flags_nx[F_UNC] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nx;
    end

    // One holding register per source class.
    for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
        rpe_src_reg #(.W(SRC_W)) src_i (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (src_ld[g]),
            .d    (msg_src),
            .q    (src_q[g])
        );
    end

    assign cor_src = src_q[S_COR];
    assign unc_src = src_q[S_UNC];

endmodule

// File: rtl/rpe_cmd_reg.sv
// Root command register holding the three severity enables.
// Assumes: a write replaces all enables; resets to zero.
module rpe_cmd_reg
    import rpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic [CMD_W-1:0] cmd_nx
);

    // Value the register takes at the next edge.
    always_comb begin
        cmd_nx = wr ? wdata : cmd_q;
    end

    // Command storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_nx;
    end

endmodule

// File: rtl/rpe_irq_unit.sv
// Interrupt generation. The level output follows the condition. The message
// request fires on a false-to-true change, found by comparing the condition
// from the current register state with the one from the next state.
// Assumes: both outputs are registered and align with the status update.
module rpe_irq_unit
    import rpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_mode,
    input  logic [FLAG_W-1:0] flags_q,
    input  logic [FLAG_W-1:0] flags_nx,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [CMD_W-1:0]  cmd_nx,
    output logic              intx,
    output logic              msi_req
);

    logic cond_now;
    logic cond_next;

    // Condition before and after this edge.
    always_comb begin
        cond_now  = irq_cond(flags_q, cmd_q);
        cond_next = irq_cond(flags_nx, cmd_nx);
    end

    // Register the level and the edge-triggered request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intx    <= 1'b0;
            msi_req <= 1'b0;
        end else begin
            intx    <= !msi_mode && cond_next;
            msi_req <= msi_mode && cond_next && !cond_now;
        end
    end

endmodule

// File: rtl/rpe_root_collector.sv
// Root port error collector top. Ties together the flag tracker, the command
// register and the interrupt unit. Samples the platform message number and
// assembles the status word. Assumes synchronous active-low reset.
module rpe_root_collector
    import rpe_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int NUM_W = 5,
    parameter int STS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [1:0]        msg_sev,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              sts_clr,
    input  logic [FLAG_W-1:0] sts_clr_mask,
    input  logic              msi_mode,
    input  logic [NUM_W-1:0]  msg_num_in,
    output logic [CMD_W-1:0]  root_cmd,
    output logic [STS_W-1:0]  root_status,
    output logic [SRC_W-1:0]  cor_src_id,
    output logic [SRC_W-1:0]  unc_src_id,
    output logic              intx,
    output logic              msi_req,
    output logic [NUM_W-1:0]  msi_vector
);

    localparam int PAD_W = STS_W - NUM_W - FLAG_W;

    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_nx;
    logic [CMD_W-1:0]  cmd_nx;
    logic [NUM_W-1:0]  num_q;

    rpe_flag_unit #(.SRC_W(SRC_W)) flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_valid(msg_valid),
        .msg_sev  (msg_sev),
        .msg_src  (msg_src),
        .clr_en   (sts_clr),
        .clr_mask (sts_clr_mask),
        .flags_q  (flags_q),
        .flags_nx (flags_nx),
        .cor_src  (cor_src_id),
        .unc_src  (unc_src_id)
    );

    rpe_cmd_reg cmd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cmd_wr),
        .wdata (cmd_wdata),
        .cmd_q (root_cmd),
        .cmd_nx(cmd_nx)
    );

    rpe_irq_unit irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .msi_mode(msi_mode),
        .flags_q (flags_q),
        .flags_nx(flags_nx),
        .cmd_q   (root_cmd),
        .cmd_nx  (cmd_nx),
        .intx    (intx),
        .msi_req (msi_req)
    );

    // Sample the platform-supplied interrupt message number.
    always_ff @(posedge clk) begin
        if (!rst_n) num_q <= '0;
        else        num_q <= msg_num_in;
    end

    assign root_status = {num_q, {PAD_W{1'b0}}, flags_q};
    assign msi_vector  = num_q;

endmodule

// File: rtl/rpe_root_collector_chk.sv
// Property checker for the root port error collector, bound to the top.
// Assumes rst_n is low for at least one edge before first release.
module rpe_root_collector_chk
    import rpe_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int NUM_W = 5,
    parameter int STS_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [1:0]        msg_sev,
    input logic              sts_clr,
    input logic [FLAG_W-1:0] sts_clr_mask,
    input logic              msi_mode,
    input logic [CMD_W-1:0]  root_cmd,
    input logic [STS_W-1:0]  root_status,
    input logic [SRC_W-1:0]  cor_src_id,
    input logic [SRC_W-1:0]  unc_src_id,
    input logic              intx,
    input logic              msi_req
);

    logic [FLAG_W-1:0] fl;
    assign fl = root_status[FLAG_W-1:0];

    // R1: state is clean when reset is released
    a_r1_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (root_cmd == '0 && fl == '0 && !intx && !msi_req));

    // R2: correctable source holds once the first one is captured
    a_r2_cor_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fl[F_COR]) && !$past(sts_clr && sts_clr_mask[F_COR]))
        |-> $stable(cor_src_id));

    // R3: uncorrectable source holds once the first one is captured
    a_r3_unc_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fl[F_UNC]) && !$past(sts_clr && sts_clr_mask[F_UNC]))
        |-> $stable(unc_src_id));

    // R4: first-fatal only rises together with fatal received
    a_r4_first_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl[F_FFAT]) |-> fl[F_FAT]);

    // R5: no flag rises without a message
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(msg_valid)) |-> ((fl & ~$past(fl)) == '0));

    // R6: the level stays low in message mode
    a_r6_intx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msi_mode) |-> !intx);

    // R7: a request lasts one cycle
    a_r7_msi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |=> !msi_req);

    // R7: a request needs message mode and a true condition
    a_r7_msi_cond: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> ($past(msi_mode) && irq_cond(fl, root_cmd)));

    // R10: a reserved-severity message alone changes no flag
    a_r10_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(msg_valid && msg_sev == 2'b11) && !$past(sts_clr))
        |-> $stable(fl));

endmodule

bind rpe_root_collector rpe_root_collector_chk #(
    .SRC_W(SRC_W), .NUM_W(NUM_W), .STS_W(STS_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_sev     (msg_sev),
    .sts_clr     (sts_clr),
    .sts_clr_mask(sts_clr_mask),
    .msi_mode    (msi_mode),
    .root_cmd    (root_cmd),
    .root_status (root_status),
    .cor_src_id  (cor_src_id),
    .unc_src_id  (unc_src_id),
    .intx        (intx),
    .msi_req     (msi_req)
);

// File: tb/rpe_root_collector_tb_top.sv
`timescale 1ns/1ps
// Bench for the root port error collector: a vector table walked by one loop,
// then directed tests for reset, message number and simultaneous clear.
module rpe_root_collector_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'b00;
    logic [15:0] msg_src = '0;
    logic        cmd_wr = 1'b0;
    logic [2:0]  cmd_wdata = '0;
    logic        sts_clr = 1'b0;
    logic [6:0]  sts_clr_mask = '0;
    logic        msi_mode = 1'b0;
    logic [4:0]  msg_num_in = 5'd0;
    logic [2:0]  root_cmd;
    logic [31:0] root_status;
    logic [15:0] cor_src_id;
    logic [15:0] unc_src_id;
    logic        intx;
    logic        msi_req;
    logic [4:0]  msi_vector;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rpe_root_collector dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src(msg_src), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .msi_mode(msi_mode),
        .msg_num_in(msg_num_in), .root_cmd(root_cmd), .root_status(root_status),
        .cor_src_id(cor_src_id), .unc_src_id(unc_src_id), .intx(intx),
        .msi_req(msi_req), .msi_vector(msi_vector)
    );

    // op: 0 message, 1 command write, 2 status clear
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sev;
        logic [15:0] src;
        logic [6:0]  dat;
        logic        mode;
        logic [6:0]  ef;
        logic [15:0] ec;
        logic [15:0] eu;
        logic        ei;
        logic        em;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 16'h0101, 7'h00, 1'b0, 7'h01, 16'h0101, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 first cor
        '{2'd0, 2'd0, 16'h0202, 7'h00, 1'b0, 7'h03, 16'h0101, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 multiple
        '{2'd1, 2'd0, 16'h0000, 7'h01, 1'b0, 7'h03, 16'h0101, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6 enable cor
        '{2'd0, 2'd1, 16'h0303, 7'h00, 1'b0, 7'h27, 16'h0101, 16'h0303, 1'b1, 1'b0, 4'd3},  // R3 nonfatal
        '{2'd0, 2'd2, 16'h0404, 7'h00, 1'b0, 7'h6F, 16'h0101, 16'h0303, 1'b1, 1'b0, 4'd4},  // R4 no first-fatal
        '{2'd2, 2'd0, 16'h0000, 7'h01, 1'b0, 7'h6E, 16'h0101, 16'h0303, 1'b0, 1'b0, 4'd5},  // R5 clear cor
        '{2'd0, 2'd3, 16'h0505, 7'h00, 1'b0, 7'h6E, 16'h0101, 16'h0303, 1'b0, 1'b0, 4'd10}, // R10 reserved
        '{2'd1, 2'd0, 16'h0000, 7'h04, 1'b0, 7'h6E, 16'h0101, 16'h0303, 1'b1, 1'b0, 4'd6},  // R6 fatal enable
        '{2'd2, 2'd0, 16'h0000, 7'h7F, 1'b0, 7'h00, 16'h0101, 16'h0303, 1'b0, 1'b0, 4'd5},  // R5 clear all
        '{2'd0, 2'd2, 16'h0606, 7'h00, 1'b0, 7'h54, 16'h0101, 16'h0606, 1'b1, 1'b0, 4'd4},  // R4 first fatal
        '{2'd2, 2'd0, 16'h0000, 7'h00, 1'b0, 7'h54, 16'h0101, 16'h0606, 1'b1, 1'b0, 4'd5},  // R5 zero mask
        '{2'd2, 2'd0, 16'h0000, 7'h7F, 1'b1, 7'h00, 16'h0101, 16'h0606, 1'b0, 1'b0, 4'd7},  // R7 enter msi
        '{2'd0, 2'd2, 16'h0707, 7'h00, 1'b1, 7'h54, 16'h0101, 16'h0707, 1'b0, 1'b1, 4'd7},  // R7 msg edge
        '{2'd0, 2'd2, 16'h0808, 7'h00, 1'b1, 7'h5C, 16'h0101, 16'h0707, 1'b0, 1'b0, 4'd7},  // R7 still true
        '{2'd1, 2'd0, 16'h0000, 7'h00, 1'b1, 7'h5C, 16'h0101, 16'h0707, 1'b0, 1'b0, 4'd7},  // R7 disable
        '{2'd1, 2'd0, 16'h0000, 7'h04, 1'b1, 7'h5C, 16'h0101, 16'h0707, 1'b0, 1'b1, 4'd7},  // R7 cmd edge
        '{2'd1, 2'd0, 16'h0000, 7'h06, 1'b1, 7'h5C, 16'h0101, 16'h0707, 1'b0, 1'b0, 4'd7},  // R7 no re-fire
        '{2'd0, 2'd0, 16'h0909, 7'h00, 1'b1, 7'h5D, 16'h0909, 16'h0707, 1'b0, 1'b0, 4'd2},  // R2 cor reload
        '{2'd2, 2'd0, 16'h0000, 7'h40, 1'b1, 7'h1D, 16'h0909, 16'h0707, 1'b0, 1'b0, 4'd7},  // R7 cond false
        '{2'd0, 2'd1, 16'h0A0A, 7'h00, 1'b1, 7'h3D, 16'h0909, 16'h0707, 1'b0, 1'b1, 4'd7}   // R7 nonfatal edge
    };

    task automatic check(input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        msg_valid = 1'b0; cmd_wr = 1'b0; sts_clr = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " cmd"}, 1, 32'(root_cmd), 32'h0);
        check({tag, " flags"}, 1, 32'(root_status[6:0]), 32'h0);
        check({tag, " cor_src"}, 1, 32'(cor_src_id), 32'h0);
        check({tag, " unc_src"}, 1, 32'(unc_src_id), 32'h0);
        check({tag, " intx"}, 1, 32'(intx), 32'h0);
        check({tag, " msi"}, 1, 32'(msi_req), 32'h0);
    endtask

    initial begin
        msg_num_in = 5'd3;
        repeat (3) @(negedge clk);
        check_reset_state("R1 initial");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            msi_mode = VEC[i].mode;
            case (VEC[i].op)
                2'd0: begin msg_valid = 1'b1; msg_sev = VEC[i].sev; msg_src = VEC[i].src; end
                2'd1: begin cmd_wr = 1'b1; cmd_wdata = VEC[i].dat[2:0]; end
                default: begin sts_clr = 1'b1; sts_clr_mask = VEC[i].dat; end
            endcase
            @(negedge clk);
            idle_inputs();
            check($sformatf("vec%0d flags", i), int'(VEC[i].req), 32'(root_status[6:0]), 32'(VEC[i].ef));
            check($sformatf("vec%0d cor_src", i), int'(VEC[i].req), 32'(cor_src_id), 32'(VEC[i].ec));
            check($sformatf("vec%0d unc_src", i), int'(VEC[i].req), 32'(unc_src_id), 32'(VEC[i].eu));
            check($sformatf("vec%0d intx", i), int'(VEC[i].req), 32'(intx), 32'(VEC[i].ei));
            check($sformatf("vec%0d msi_req", i), int'(VEC[i].req), 32'(msi_req), 32'(VEC[i].em));
        end

        // R6: command read-back after the table
        check("R6 cmd readback", 6, 32'(root_cmd), 32'h6);

        // R8: message number reaches the status word and the vector
        msg_num_in = 5'd19;
        @(negedge clk);
        check("R8 status field", 8, 32'(root_status[31:27]), 32'd19);
        check("R8 vector", 8, 32'(msi_vector), 32'd19);
        check("R8 pad bits", 8, 32'(root_status[26:7]), 32'h0);

        // R9: clear of cor and a cor message together -> fresh capture, no multiple
        sts_clr = 1'b1; sts_clr_mask = 7'h01;
        msg_valid = 1'b1; msg_sev = 2'b00; msg_src = 16'h0B0B;
        @(negedge clk);
        idle_inputs();
        check("R9 flags", 9, 32'(root_status[6:0]), 32'h3D);
        check("R9 cor_src", 9, 32'(cor_src_id), 32'h0B0B);

        // R1: reset in mid-run returns everything to zero
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("R1 midrun");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule